// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked one-shot. It watches three asynchronous control lines: an active-low launch line, an active-high launch line and an active-low cancel line. When one of the permitted edge patterns occurs, it drives a pulse on `q_o` whose length is a whole number of clock cycles. The length comes from a 16-bit width input. A complementary output `qn_o` is also provided.

A qualifying edge that arrives while a pulse is running reloads the full width, so the pulse stretches to end one programmed width after the most recent launch. Pulling the cancel line low cuts a running pulse short and holds the output idle until the line returns high. A return of the cancel line to high is a third launch source, but only when the other two lines are already in their enabling levels.

Every control line passes through a two-flop synchronizer and then an edge detector. As a result, every input reaches the output with a fixed latency of three clock edges. The width is sampled at the moment a launch is taken. A synchronous active-high reset returns the block to idle.

Top module: `osp_oneshot`

## Requirements
- R1: While the synchronized cancel line is low, `q_o` is 0 and `qn_o` is 1, whatever the two launch lines do.
- R2: With cancel high and `b_i` high, a 1-to-0 transition of `a_n_i` launches a pulse.
- R3: With cancel high and `a_n_i` low, a 0-to-1 transition of `b_i` launches a pulse.
- R4: With `a_n_i` low and `b_i` high, a 0-to-1 transition of `clr_n_i` launches a pulse.
- R5: While `a_n_i` stays high, or while `b_i` stays low, no pulse is launched by activity on the other line.
- R6: A launch taken while a pulse is running reloads the count, so `q_o` stays high without a gap and falls exactly `width_i` cycles after the latest launch takes effect.
- R7: A cancel that falls during a pulse forces `q_o` low three clock edges after the input change, shortening the pulse.
- R8: `qn_o` is always the bitwise complement of `q_o`.
- R9: A launch holds `q_o` high for exactly `width_i` cycles, with a width of 0 treated as 1 cycle. The width is the value present on the clock edge at which the launch is taken.
- R10: `q_o` rises after the third rising clock edge that follows the input change causing a launch: two edges for the synchronizer and one for the counter load.
- R11: When cancel rises in the same cycle as a qualifying `b_i` rise or `a_n_i` fall, exactly one pulse of the programmed width is produced.
- R12: When `rst_i` is high on a clock edge, `q_o` is 0 after that edge and the pulse counter is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| a_n_i | input | 1 | Active-low launch line, asynchronous |
| b_i | input | 1 | Active-high launch line, asynchronous |
| clr_n_i | input | 1 | Active-low cancel line, asynchronous; its rise can launch |
| width_i | input | CNT_W (16) | Pulse length in clock cycles |
| q_o | output | 1 | Pulse output, active high |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
Several properties are checked on every cycle. A low cancel empties the counter on the next edge. A launch loads the zero-corrected width. An idle counter counts down by one. `q_o` only rises after a decoded launch, reset forces the output low, and a held-high `a_n_i` or held-low `b_i` never decodes a launch. Some behaviours can only be shown by the bench's scenarios, which compare the outputs against a behavioural model on every cycle and measure whole pulses: the exact three-edge latency, the stretch of a pulse by a retrigger, a simultaneous cancel rise producing a single pulse, and the gated launch through a cancel release.

// File: rtl/osp_pkg.sv
package osp_pkg;

    // Default width of the pulse-length counter, in bits.
    localparam int unsigned WIDTH_BITS = 16;

    // Number of synchronizer flops in front of the edge detector.
    localparam int unsigned SYNC_DEPTH = 2;

    // Synchronized view of the three control lines.
    typedef struct packed {
        logic a_n;
        logic b;
        logic clr_n;
    } ctl_t;

    // Idle levels: no launch pending, cancel released.
    localparam ctl_t CTL_IDLE = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};

    // Per-cycle edge events.
    typedef struct packed {
        logic fall_a;
        logic rise_b;
        logic rise_clr;
    } edges_t;

    // Launch decode: each edge is gated by the levels of the other lines.
    function automatic logic launch_of(input ctl_t cur, input edges_t e);
        logic via_a;
        logic via_b;
        logic via_c;
        via_a = e.fall_a & cur.b;
        via_b = e.rise_b & ~cur.a_n;
        via_c = e.rise_clr & ~cur.a_n & cur.b;
        return cur.clr_n & (via_a | via_b | via_c);
    endfunction

endpackage

// File: rtl/osp_sync.sv
module osp_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = osp_pkg::SYNC_DEPTH,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    logic [N-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) stg[i] <= RST_VAL;
                else       stg[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) stg[i] <= RST_VAL;
                else       stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/osp_edge.sv
module osp_edge
    import osp_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  ctl_t   cur_i,
    output edges_t edges_o,
    output logic   launch_o,
    output logic   clr_ok_o
);

    ctl_t prev;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev <= CTL_IDLE;
        else       prev <= cur_i;
    end

    always_comb begin
        edges_o.fall_a   = prev.a_n & ~cur_i.a_n;
        edges_o.rise_b   = ~prev.b & cur_i.b;
        edges_o.rise_clr = ~prev.clr_n & cur_i.clr_n;
    end

    assign launch_o = launch_of(cur_i, edges_o);
    assign clr_ok_o = cur_i.clr_n;

    // A held high on both samples, or B held low on both: no launch.
    AST_BLOCKED_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (rst_i)
        ((prev.a_n && cur_i.a_n) || (!prev.b && !cur_i.b)) |-> !launch_o); // R5

endmodule

// File: rtl/osp_timer.sv
module osp_timer #(
    parameter int unsigned CNT_W = osp_pkg::WIDTH_BITS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             launch_i,
    input  logic             clr_ok_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             busy_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    assign load_val = (width_i == '0) ? CNT_W'(1) : width_i;

    always_ff @(posedge clk_i) begin
        if (rst_i)             cnt <= '0;
        else if (!clr_ok_i)    cnt <= '0;
        else if (launch_i)     cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    assign busy_o = (cnt != '0);

    AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (rst_i)
        !clr_ok_i |=> (cnt == '0)); // R1

    AST_LOAD_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_ok_i && launch_i) |=>
            (cnt == (($past(width_i) == '0) ? CNT_W'(1) : $past(width_i)))); // R9

    AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_ok_i && !launch_i && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R6

    AST_RESET_EMPTIES: assert property (@(posedge clk_i)
        rst_i |=> (cnt == '0)); // R12

endmodule

// File: rtl/osp_oneshot.sv
module osp_oneshot
    import osp_pkg::*;
#(
    parameter int unsigned CNT_W  = WIDTH_BITS,
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             a_n_i,
    input  logic             b_i,
    input  logic             clr_n_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             q_o,
    output logic             qn_o
);

    localparam int unsigned NCTL = $bits(ctl_t);

    logic [NCTL-1:0] raw;
    logic [NCTL-1:0] synced;
    ctl_t            cur;
    edges_t          edges;
    logic            launch;
    logic            clr_ok;
    logic            busy;

    assign raw = {a_n_i, b_i, clr_n_i};

    osp_sync #(
        .N       (NCTL),
        .STAGES  (STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw),
        .q_o   (synced)
    );

    assign cur = ctl_t'(synced);

    osp_edge u_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cur_i    (cur),
        .edges_o  (edges),
        .launch_o (launch),
        .clr_ok_o (clr_ok)
    );

    osp_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .launch_i (launch),
        .clr_ok_i (clr_ok),
        .width_i  (width_i),
        .busy_o   (busy)
    );

    assign q_o  = busy;
    assign qn_o = ~busy;

    AST_RISE_NEEDS_LAUNCH: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(q_o) |-> $past(launch)); // R2

    AST_RESET_LOW: assert property (@(posedge clk_i)
        rst_i |=> !q_o); // R12

    AST_EDGE_DRIVES_LAUNCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_ok && edges.rise_b && !cur.a_n) |=> q_o); // R3

endmodule

// File: tb/tb_osp_oneshot.sv
`timescale 1ns/1ps
module tb_osp_oneshot;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_n = 1'b1;
    logic        b   = 1'b0;
    logic        c_n = 1'b1;
    logic [15:0] w   = 16'd5;
    logic        q_o;
    logic        qn_o;

    int total = 0;
    int bad   = 0;
    string cur_req = "R12";
    bit done = 0;

    always #2.5 clk = ~clk;

    osp_oneshot dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .a_n_i   (a_n),
        .b_i     (b),
        .clr_n_i (c_n),
        .width_i (w),
        .q_o     (q_o),
        .qn_o    (qn_o)
    );

    // Behavioural reference: input history per edge and a remaining-cycle integer.
    bit h1a = 1, h1b = 0, h1c = 1;
    bit h2a = 1, h2b = 0, h2c = 1;
    bit h3a = 1, h3b = 0, h3c = 1;
    int rem = 0;

    always @(posedge clk) begin
        bit go;
        if (rst) begin
            rem = 0;
            {h1a, h1b, h1c} = 3'b101;
            {h2a, h2b, h2c} = 3'b101;
            {h3a, h3b, h3c} = 3'b101;
        end else begin
            go = h2c && ((h3a && !h2a && h2b) ||
                         (!h3b && h2b && !h2a) ||
                         (!h3c && h2c && !h2a && h2b));
            if (!h2c)      rem = 0;
            else if (go)   rem = (w == 0) ? 1 : int'(w);
            else if (rem > 0) rem = rem - 1;
            {h3a, h3b, h3c} = {h2a, h2b, h2c};
            {h2a, h2b, h2c} = {h1a, h1b, h1c};
            {h1a, h1b, h1c} = {a_n, b, c_n};
        end
    end

    // Per-cycle comparison and pulse statistics, sampled away from the edge.
    int hi_cycles = 0;
    int rises = 0;
    bit last_q = 0;

    always @(negedge clk) begin
        bit exp_q;
        exp_q = (rem > 0);
        total++;
        if (q_o !== exp_q || qn_o !== !exp_q) begin
            bad++;
            $display("FAIL %s/R8 per-cycle: q=%b qn=%b expected q=%b qn=%b",
                     cur_req, q_o, qn_o, exp_q, !exp_q);
        end
        if (q_o === 1'b1) hi_cycles++;
        if (q_o === 1'b1 && !last_q) rises++;
        last_q = (q_o === 1'b1);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int h0;
        int r0;
        step(3);
        chk(q_o == 0 && qn_o == 1, "R12 reset state", q_o, 0);
        rst = 0;
        step(4);

        // R2 + R10: falling A with B high, width 5, latency three edges.
        cur_req = "R2";
        b = 1; step(5);
        h0 = hi_cycles; r0 = rises;
        a_n = 0; step(2);
        chk(q_o == 0, "R10 still low after two edges", q_o, 0);
        step(1);
        chk(q_o == 1, "R10 high after third edge", q_o, 1);
        step(8);
        chk(hi_cycles - h0 == 5, "R2 pulse length", hi_cycles - h0, 5);
        chk(rises - r0 == 1, "R2 single rise", rises - r0, 1);

        // R3 + R9: rising B with A low, width 0 acts as 1.
        cur_req = "R3";
        w = 16'd0; b = 0; step(5);
        h0 = hi_cycles;
        b = 1; step(8);
        chk(hi_cycles - h0 == 1, "R9 zero width gives one cycle", hi_cycles - h0, 1);

        // R1 + R4: cancel low holds idle, its rise with A low and B high launches.
        cur_req = "R1";
        w = 16'd4; c_n = 0; step(4);
        h0 = hi_cycles;
        b = 0; step(2); b = 1; step(2); a_n = 1; step(2); a_n = 0; step(4);
        chk(hi_cycles - h0 == 0 && qn_o == 1, "R1 outputs held idle", hi_cycles - h0, 0);
        cur_req = "R4";
        h0 = hi_cycles;
        c_n = 1; step(9);
        chk(hi_cycles - h0 == 4, "R4 cancel-release pulse", hi_cycles - h0, 4);

        // R5: A held high blocks B; B held low blocks A.
        cur_req = "R5";
        a_n = 1; b = 0; step(4);
        h0 = hi_cycles;
        for (int i = 0; i < 3; i++) begin b = 1; step(2); b = 0; step(2); end
        for (int i = 0; i < 3; i++) begin a_n = 0; step(2); a_n = 1; step(2); end
        step(4);
        chk(hi_cycles - h0 == 0, "R5 no pulse when gated", hi_cycles - h0, 0);

        // R6: retrigger after 4 cycles stretches a width-10 pulse to 14+1.
        cur_req = "R6";
        w = 16'd10; a_n = 0; b = 0; step(5);
        h0 = hi_cycles; r0 = rises;
        b = 1; step(4);
        b = 0; step(1);
        b = 1; step(16);
        chk(hi_cycles - h0 == 15, "R6 stretched length", hi_cycles - h0, 15);
        chk(rises - r0 == 1, "R6 no gap", rises - r0, 1);

        // R7: cancel during a width-20 pulse shortens it to 6 cycles.
        cur_req = "R7";
        w = 16'd20; b = 0; step(5);
        h0 = hi_cycles;
        b = 1; step(6);
        c_n = 0; step(3);
        chk(q_o == 0, "R7 cancelled output low", q_o, 0);
        step(20);
        chk(hi_cycles - h0 == 6, "R7 shortened length", hi_cycles - h0, 6);
        a_n = 1; step(3); c_n = 1; step(5);

        // R11: cancel rise together with B rise, A low: one pulse.
        cur_req = "R11";
        w = 16'd7; a_n = 0; b = 0; c_n = 0; step(5);
        h0 = hi_cycles; r0 = rises;
        c_n = 1; b = 1; step(12);
        chk(rises - r0 == 1, "R11 single pulse count", rises - r0, 1);
        chk(hi_cycles - h0 == 7, "R11 single pulse length", hi_cycles - h0, 7);

        // R12: reset in the middle of a pulse.
        cur_req = "R12";
        w = 16'd30; a_n = 1; b = 1; step(5);
        a_n = 0; step(10);
        a_n = 1; b = 0; step(1);
        rst = 1; step(1);
        chk(q_o == 0 && qn_o == 1, "R12 reset ends pulse", q_o, 0);
        rst = 0; step(6);
        chk(q_o == 0, "R12 stays idle after reset", q_o, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule